// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block decides, every cycle, whether a hart should take an interrupt and which cause number to report. It forms the candidate set from the pending and enable vectors. It then routes each candidate through the enable condition of the privilege level that owns it: the machine level, or the supervisor level when the candidate's delegation bit is set. From the survivors it picks the lowest-numbered one. The result is a take strobe and a full-width cause word whose top bit marks it as an interrupt.

The selection logic is purely combinational. A parameter places an optional register stage after it, so that the decision can be timed into the trap-entry pipeline one cycle later. Trap entry itself, storage of the control registers and the sources of the pending bits are outside the block. The block has no state machine. Its only states are the reset value and the captured value of the optional output register.

Top module: `irq_sel_top`

## Requirements
- R1: An interrupt is a candidate only if its bit is set in both `pend_vec` and `ena_vec`. A pending bit whose enable is clear never causes a take.
- R2: Machine-level interrupts are enabled when `cur_priv` is below machine (codes 0, 1 and 2), or when `cur_priv` is machine (code 3) and `m_gie` is 1.
- R3: A candidate whose `deleg_vec` bit is 0 is taken only while machine-level interrupts are enabled. At machine level with `m_gie` 0, no interrupt is taken at all.
- R4: A candidate whose `deleg_vec` bit is 1 is taken only when `cur_priv` is user (code 0), or when it is supervisor (code 1) and `s_gie` is 1. With the reserved code 2 or machine code 3, delegated candidates are blocked.
- R5: When several candidates survive gating, the lowest bit index wins.
- R6: When an interrupt is taken, `cause_o` bit XLEN-1 is 1. The winning index sits in the low $clog2(XLEN) bits, and all other bits are 0.
- R7: When no candidate survives gating, `take_o` is 0 and `cause_o` is all zeros.
- R8: With REG_OUT=1 (the default), both outputs reflect the inputs sampled at the previous rising clock edge. With REG_OUT=0, they follow the inputs in the same cycle.
- R9: While `rst_n` is low, the registered outputs are 0 whatever the inputs are.
- R10: XLEN is 32 or 64, and the search covers all XLEN bits, including bit XLEN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_vec | input | XLEN | Interrupt pending bits |
| ena_vec | input | XLEN | Interrupt enable bits |
| deleg_vec | input | XLEN | 1 = interrupt owned by supervisor level |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Global machine interrupt enable |
| s_gie | input | 1 | Global supervisor interrupt enable |
| take_o | output | 1 | Interrupt should be taken |
| cause_o | output | XLEN | Interrupt flag in the top bit, winning index in the low bits |

## Verification
With the default register stage, each decision is due exactly one rising edge after its inputs settle. The bench therefore drives inputs on a falling edge and samples on the following falling edge, after one rising edge has passed. One directed test also samples just before that rising edge, to confirm that the previous result is still held. The checker relates each output to the inputs one cycle earlier. In the combinational variant, it relates them to the inputs of the same cycle.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pend_vec,
    input  logic [XLEN-1:0] ena_vec,
    input  logic [XLEN-1:0] deleg_vec,
    input  logic [1:0]      cur_priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic [XLEN-1:0] gated_vec
);

    logic            lvl_m_on;
    logic            lvl_s_on;
    logic [XLEN-1:0] cand_vec;

    // Level enables: anything strictly below a level is always interruptible by it.
    always_comb begin
        lvl_m_on = (cur_priv < 2'(PRIV_M)) || ((cur_priv == 2'(PRIV_M)) && m_gie);
        lvl_s_on = (cur_priv < 2'(PRIV_S)) || ((cur_priv == 2'(PRIV_S)) && s_gie);
    end

    always_comb begin
        cand_vec  = pend_vec & ena_vec;
        gated_vec = (cand_vec & ~deleg_vec & {XLEN{lvl_m_on}})
                  | (cand_vec &  deleg_vec & {XLEN{lvl_s_on}});
    end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int XLEN  = 64,
    parameter int IDX_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  req_vec,
    output logic             hit,
    output logic [IDX_W-1:0] win_idx
);

    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        hit     = |req_vec;
        win_idx = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
    import irq_sel_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int REG_OUT = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_vec,
    input  logic [XLEN-1:0] ena_vec,
    input  logic [XLEN-1:0] deleg_vec,
    input  logic [1:0]      cur_priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);

    localparam int IDX_W = $clog2(XLEN);
    localparam int PAD_W = XLEN - 1 - IDX_W;

    logic [XLEN-1:0]  gated_vec;
    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;
    logic             take_nxt;
    logic [XLEN-1:0]  cause_nxt;

    irq_gate #(.XLEN(XLEN)) u_gate (
        .pend_vec  (pend_vec),
        .ena_vec   (ena_vec),
        .deleg_vec (deleg_vec),
        .cur_priv  (cur_priv),
        .m_gie     (m_gie),
        .s_gie     (s_gie),
        .gated_vec (gated_vec)
    );

    irq_lowest_pick #(.XLEN(XLEN), .IDX_W(IDX_W)) u_pick (
        .req_vec (gated_vec),
        .hit     (pick_hit),
        .win_idx (pick_idx)
    );

    always_comb begin
        take_nxt  = pick_hit;
        cause_nxt = pick_hit ? {1'b1, {PAD_W{1'b0}}, pick_idx} : '0;
    end

    generate
        if (REG_OUT != 0) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    take_o  <= 1'b0;
                    cause_o <= '0;
                end else begin
                    take_o  <= take_nxt;
                    cause_o <= cause_nxt;
                end
            end
        end else begin : g_comb
            assign take_o  = take_nxt;
            assign cause_o = cause_nxt;
        end
    endgenerate

endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk #(
    parameter int XLEN    = 64,
    parameter int REG_OUT = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pend_vec,
    input logic [XLEN-1:0] ena_vec,
    input logic [1:0]      cur_priv,
    input logic            m_gie,
    input logic            take_o,
    input logic [XLEN-1:0] cause_o
);

    localparam int IDX_W = $clog2(XLEN);

    logic [IDX_W-1:0] idx_seen;
    assign idx_seen = cause_o[IDX_W-1:0];

    // R6: a take always carries the interrupt flag
    assert_cause_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cause_o[XLEN-1]);

    // R6: bits between the flag and the index stay clear
    assert_cause_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cause_o[XLEN-2:IDX_W] == '0));

    // R7: no take means an all-zero cause
    assert_idle_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0));

    generate
        if (REG_OUT != 0) begin : g_seq
            // R1 and R8: the reported index was pending and enabled one cycle earlier
            assert_win_is_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
                take_o |-> ($past(pend_vec & ena_vec) >> idx_seen) & XLEN'(1));

            // R1: an empty candidate set yields no take
            assert_no_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
                ($past((pend_vec & ena_vec) == '0)) |-> !take_o);

            // R3: machine level with its global enable off masks everything
            assert_m_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(cur_priv == 2'b11 && !m_gie)) |-> !take_o);
        end else begin : g_cmb
            assert_win_is_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
                take_o |-> ((pend_vec & ena_vec) >> idx_seen) & XLEN'(1));

            assert_no_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
                ((pend_vec & ena_vec) == '0) |-> !take_o);

            assert_m_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_priv == 2'b11 && !m_gie) |-> !take_o);
        end
    endgenerate

endmodule

bind irq_sel_top irq_sel_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_vec (pend_vec),
    .ena_vec  (ena_vec),
    .cur_priv (cur_priv),
    .m_gie    (m_gie),
    .take_o   (take_o),
    .cause_o  (cause_o)
);

// File: tb/tb_irq_sel_top.sv
module tb_irq_sel_top;

    localparam int CLK_P = 10;
    localparam int XLEN  = 64;
    localparam int NVEC  = 12;

    // Row layout: pend[58:43] ena[42:27] deleg[26:11] priv[10:9] mie[8] sie[7] take[6] idx[5:0]
    localparam logic [58:0] VEC [NVEC] = '{
        {16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 6'd7},  // R2 M with mie
        {16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 6'd0},  // R3 M without mie
        {16'h0080, 16'h0080, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 6'd7},  // R2 S is below M
        {16'h0022, 16'h0022, 16'h0022, 2'd1, 1'b1, 1'b0, 1'b0, 6'd0},  // R4 S without sie
        {16'h0022, 16'h0022, 16'h0022, 2'd1, 1'b0, 1'b1, 1'b1, 6'd1},  // R4 S with sie
        {16'h0022, 16'h0022, 16'h0022, 2'd0, 1'b0, 1'b0, 1'b1, 6'd1},  // R4 U below S
        {16'h0022, 16'h0022, 16'h0022, 2'd3, 1'b1, 1'b1, 1'b0, 6'd0},  // R4 delegated blocked at M
        {16'h00A2, 16'h00A2, 16'h0022, 2'd1, 1'b0, 1'b0, 1'b1, 6'd7},  // R3 mixed ownership
        {16'h0888, 16'h0808, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 6'd3},  // R5 lowest index
        {16'hFFFF, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 6'd0},  // R1 nothing enabled
        {16'h8001, 16'h8001, 16'h0001, 2'd3, 1'b1, 1'b1, 1'b1, 6'd15}, // R5 low bit gated off
        {16'h0003, 16'h0003, 16'h0001, 2'd2, 1'b0, 1'b1, 1'b1, 6'd1}   // R4 reserved level
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] pend_vec = '1;
    logic [XLEN-1:0] ena_vec = '1;
    logic [XLEN-1:0] deleg_vec = '0;
    logic [1:0]      cur_priv = 2'd0;
    logic            m_gie = 1'b1;
    logic            s_gie = 1'b1;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    irq_sel_top #(.XLEN(XLEN), .REG_OUT(1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_vec  (pend_vec),
        .ena_vec   (ena_vec),
        .deleg_vec (deleg_vec),
        .cur_priv  (cur_priv),
        .m_gie     (m_gie),
        .s_gie     (s_gie),
        .take_o    (take_o),
        .cause_o   (cause_o)
    );

    function automatic logic [XLEN-1:0] exp_cause(input logic tk, input int idx);
        return tk ? ((XLEN'(1) << (XLEN - 1)) | XLEN'(idx)) : '0;
    endfunction

    task automatic check(input string req, input logic exp_tk, input logic [XLEN-1:0] exp_cs);
        checks++;
        if (take_o !== exp_tk || cause_o !== exp_cs) begin
            errors++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     req, take_o, cause_o, exp_tk, exp_cs);
        end
    endtask

    task automatic drive(input logic [XLEN-1:0] p, input logic [XLEN-1:0] e,
                         input logic [XLEN-1:0] d, input logic [1:0] pr,
                         input logic mi, input logic si);
        @(negedge clk);
        pend_vec  = p;
        ena_vec   = e;
        deleg_vec = d;
        cur_priv  = pr;
        m_gie     = mi;
        s_gie     = si;
    endtask

    initial begin
        // R9: active inputs held during reset must not reach the outputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset", 1'b0, '0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            drive(XLEN'(VEC[k][58:43]), XLEN'(VEC[k][42:27]), XLEN'(VEC[k][26:11]),
                  VEC[k][10:9], VEC[k][8], VEC[k][7]);
            @(negedge clk);
            check($sformatf("R5/R6 vector %0d", k), VEC[k][6],
                  exp_cause(VEC[k][6], int'(VEC[k][5:0])));
        end

        // R10: only the top bit pending, in user mode
        drive({1'b1, 63'b0}, '1, '0, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 top bit", 1'b1, exp_cause(1'b1, XLEN - 1));

        // R7: idle state after removing all pending bits
        drive('0, '1, '0, 2'd0, 1'b1, 1'b1);
        @(negedge clk);
        check("R7 idle", 1'b0, '0);

        // R8: one-cycle latency; old value still held just before the edge
        drive(XLEN'(64'h10), '1, '0, 2'd3, 1'b1, 1'b0);
        #1;
        check("R8 before edge", 1'b0, '0);
        @(negedge clk);
        check("R8 after edge", 1'b1, exp_cause(1'b1, 4));

        // R1: pending bit with enable cleared is ignored, at the output
        drive(XLEN'(64'h10), ~XLEN'(64'h10), '0, 2'd0, 1'b1, 1'b1);
        @(negedge clk);
        check("R1 enable clear", 1'b0, '0);

        // R9: asynchronous reset clears a held take
        drive(XLEN'(64'h2), '1, '0, 2'd0, 1'b1, 1'b1);
        @(negedge clk);
        check("R9 pre-reset", 1'b1, exp_cause(1'b1, 1));
        rst_n = 1'b0;
        #1;
        check("R9 async reset", 1'b0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: take=%0b cause=%h expected completion", take_o, cause_o);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule